// File: doc/BRIEF.md
# Two-Bit Shift-Register Mealy Sequence Machine

This block is a three-state Mealy machine whose whole next-state logic is a two-bit shift register. On every rising clock edge the serial input `x` enters the low state bit and the previous low bit moves up into the high bit. The state codes were picked at design time so that each code is the input history that forces the machine into that state. As a result, the shift alone produces the correct transitions, and only the output `z` needs any decoding.

The abstract states are A, B and C. A zero input sends every state to B. A one input moves B to C, C to A, and keeps A in A. The output goes high only while the machine sits in C with `x` high, which is the step that leads to A. State B owns two codes, so the block also brings out a decoded state label that a checker can compare against an abstract model. A synchronous `init` loads code 00 (state B).

Top module: `mealy_shift_fsm`

## Requirements
- R1: With `init` high at a rising edge, `q` becomes 00 after that edge and `stateLabel` reads B. This holds whatever the value of `x`.
- R2: With `init` low, each rising edge loads `q[1]` with the old `q[0]` and loads `q[0]` with `x`.
- R3: With `init` low and `x` = 0 at an edge, the state after that edge is B, whatever the starting state.
- R4: With `init` low and `x` = 1 at an edge, B goes to C, C goes to A and A stays in A.
- R5: `z` is combinational and is 1 exactly when `q` = 01 (state C) and `x` = 1. It depends on `q` and `x` only, and not on `init`.
- R6: `stateLabel` decodes `q` as follows: 00 and 10 give B = 0, 01 gives C = 1, and 11 gives A = 2. The value 3 never appears.
- R7: The input pair 0 then 1 leaves the machine in C from any start state. The pair 1 then 1 leaves it in A from any start state.
- R8: Over any input stream, `z` and `stateLabel` match an abstract three-state transition table run in step with the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| init | input | 1 | Synchronous load of state B (code 00) |
| x | input | 1 | Serial input bit |
| z | output | 1 | Mealy output, high on the C-to-A step |
| q | output | 2 | State bits; q[0] is the newest input |
| stateLabel | output | 2 | Decoded state: B = 0, C = 1, A = 2 |

## Verification
The output `z` is due in the same cycle as the input `x` that it depends on. The bench therefore drives `x` on the falling edge and samples `z` shortly afterwards, before the next rising edge. `q` and `stateLabel` change one rising edge after the input that causes the change, so they are checked in the following low phase, against the state the expected table or the model held before that edge. The checks that a synchronizing input pair works apply the pair from each start state, counting two edges, and read the label after the second edge.

// File: rtl/mealy_shift_pkg.sv
package mealy_shift_pkg;
  localparam int STATE_W = 2;
  localparam int LABEL_W = 2;

  typedef enum logic [LABEL_W-1:0] {
    LBL_B = 2'd0,
    LBL_C = 2'd1,
    LBL_A = 2'd2
  } stateLabel_e;

  typedef struct packed {
    logic clearState;
    logic shiftIn;
  } pathStrobe_t;
endpackage

// File: rtl/mealy_shift_path.sv
module mealy_shift_path
  import mealy_shift_pkg::*;
(
  input  logic               clk,
  input  pathStrobe_t        strb,
  input  logic               x,
  output logic [STATE_W-1:0] q
);
  logic [STATE_W-1:0] nextQ;

  for (genvar i = 0; i < STATE_W; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign nextQ[i] = x;
    end else begin : g_tail
      assign nextQ[i] = q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (strb.clearState) begin
      q <= '0;
    end else if (strb.shiftIn) begin
      q <= nextQ;
    end
  end

  // R1: init clears the state on the next edge
  p_init_clears_r1: assert property (@(posedge clk) strb.clearState |=> (q == 2'b00));

  // R2: plain shift of the serial input
  p_shift_r2: assert property (@(posedge clk) disable iff (strb.clearState)
    1'b1 |=> (q == {$past(q[0]), $past(x)}));
endmodule

// File: rtl/mealy_shift_ctrl.sv
module mealy_shift_ctrl
  import mealy_shift_pkg::*;
(
  input  logic               clk,
  input  logic               init,
  input  logic               x,
  input  logic [STATE_W-1:0] q,
  output pathStrobe_t        strb,
  output logic               z,
  output stateLabel_e        label
);
  always_comb begin
    strb.clearState = init;
    strb.shiftIn    = !init;
  end

  always_comb begin
    unique case (q)
      2'b01:   label = LBL_C;
      2'b11:   label = LBL_A;
      default: label = LBL_B;
    endcase
  end

  assign z = x & ~q[1] & q[0];

  // R3: a zero input always lands in B
  p_zero_to_b_r3: assert property (@(posedge clk) disable iff (init)
    !x |=> (label == LBL_B));

  // R4: a one input moves B to C
  p_one_b_to_c_r4: assert property (@(posedge clk) disable iff (init)
    (x && label == LBL_B) |=> (label == LBL_C));

  // R4: a one input moves C or A to A
  p_one_to_a_r4: assert property (@(posedge clk) disable iff (init)
    (x && label != LBL_B) |=> (label == LBL_A));

  // R5: a high output is always followed by state A
  p_z_then_a_r5: assert property (@(posedge clk) disable iff (init)
    z |=> (label == LBL_A));

  // R6: the label never takes the unused value
  p_label_legal_r6: assert property (@(posedge clk) disable iff (init)
    label != 2'd3);
endmodule

// File: rtl/mealy_shift_fsm.sv
module mealy_shift_fsm
  import mealy_shift_pkg::*;
(
  input  logic               clk,
  input  logic               init,
  input  logic               x,
  output logic               z,
  output logic [STATE_W-1:0] q,
  output logic [LABEL_W-1:0] stateLabel
);
  pathStrobe_t strb;
  stateLabel_e label;

  mealy_shift_ctrl ctrl_i (
    .clk   (clk),
    .init  (init),
    .x     (x),
    .q     (q),
    .strb  (strb),
    .z     (z),
    .label (label)
  );

  mealy_shift_path path_i (
    .clk  (clk),
    .strb (strb),
    .x    (x),
    .q    (q)
  );

  assign stateLabel = label;
endmodule

// File: tb/mealy_shift_fsm_tb.sv
module mealy_shift_fsm_tb_top;
  logic clk = 1'b0;
  logic init = 1'b1;
  logic x = 1'b0;
  logic z;
  logic [1:0] q;
  logic [1:0] stateLabel;

  int applied = 0;
  int errs = 0;
  bit done = 1'b0;

  localparam logic [1:0] S_B = 2'd0, S_C = 2'd1, S_A = 2'd2;

  mealy_shift_fsm dut_i (
    .clk(clk), .init(init), .x(x), .z(z), .q(q), .stateLabel(stateLabel)
  );

  always #5 clk = ~clk;

  // entry: {init, x, expected q, expected z, expected label}
  localparam int NVEC = 17;
  localparam logic [6:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 2'b00, 1'b0, S_B},
    {1'b0, 1'b1, 2'b00, 1'b0, S_B},
    {1'b0, 1'b1, 2'b01, 1'b1, S_C},
    {1'b0, 1'b1, 2'b11, 1'b0, S_A},
    {1'b0, 1'b0, 2'b11, 1'b0, S_A},
    {1'b0, 1'b1, 2'b10, 1'b0, S_B},
    {1'b0, 1'b0, 2'b01, 1'b0, S_C},
    {1'b0, 1'b0, 2'b10, 1'b0, S_B},
    {1'b0, 1'b0, 2'b00, 1'b0, S_B},
    {1'b0, 1'b1, 2'b00, 1'b0, S_B},
    {1'b1, 1'b1, 2'b01, 1'b1, S_C},
    {1'b0, 1'b1, 2'b00, 1'b0, S_B},
    {1'b0, 1'b1, 2'b01, 1'b1, S_C},
    {1'b0, 1'b0, 2'b11, 1'b0, S_A},
    {1'b0, 1'b1, 2'b10, 1'b0, S_B},
    {1'b0, 1'b1, 2'b01, 1'b1, S_C},
    {1'b0, 1'b0, 2'b11, 1'b0, S_A}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // apply inputs in the low phase, wait for the edge, settle past it
  task automatic step(input logic i, input logic xi);
    @(negedge clk);
    init = i;
    x = xi;
    @(posedge clk);
    #2;
  endtask

  function automatic logic [1:0] modelNext(input logic [1:0] s, input logic xi);
    if (!xi) return S_B;
    case (s)
      S_B:     return S_C;
      default: return S_A;
    endcase
  endfunction

  initial begin
    logic [1:0] mState;
    // reset
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset q", q, 2'b00);
    check("R1 reset label", stateLabel, S_B);

    // vector table walk
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      init = VEC[i][6];
      x = VEC[i][5];
      #2;
      check($sformatf("R2 vec%0d q", i), q, VEC[i][4:3]);
      check($sformatf("R5 vec%0d z", i), z, VEC[i][2]);
      check($sformatf("R6 vec%0d label", i), stateLabel, VEC[i][1:0]);
    end

    // R1: init wins over x = 1 from state A
    step(1'b0, 1'b1); step(1'b0, 1'b1);
    check("R4 reach A", stateLabel, S_A);
    step(1'b1, 1'b1);
    check("R1 init from A q", q, 2'b00);

    // R3: zero from each state
    step(1'b0, 1'b0);
    check("R3 B stays B", stateLabel, S_B);
    step(1'b0, 1'b1); step(1'b0, 1'b0);
    check("R3 C to B q", q, 2'b10);
    check("R6 code 10 is B", stateLabel, S_B);

    // R7: synchronizing pairs from each start state
    for (int s = 0; s < 3; s++) begin
      step(1'b1, 1'b0);
      if (s == 1) step(1'b0, 1'b1);
      if (s == 2) begin step(1'b0, 1'b1); step(1'b0, 1'b1); end
      step(1'b0, 1'b0); step(1'b0, 1'b1);
      check($sformatf("R7 sync C from start %0d", s), stateLabel, S_C);
    end
    for (int s = 0; s < 3; s++) begin
      step(1'b1, 1'b0);
      if (s == 1) step(1'b0, 1'b1);
      if (s == 2) begin step(1'b0, 1'b1); step(1'b0, 1'b1); end
      step(1'b0, 1'b1); step(1'b0, 1'b1);
      check($sformatf("R7 sync A from start %0d", s), stateLabel, S_A);
    end

    // R8: random stream against the abstract table
    step(1'b1, 1'b0);
    mState = S_B;
    for (int n = 0; n < 3000; n++) begin
      logic ri, rx;
      ri = ($urandom_range(0, 63) == 0);
      rx = $urandom_range(0, 1);
      @(negedge clk);
      init = ri;
      x = rx;
      #2;
      check("R8 random z", z, (mState == S_C) && rx);
      check("R8 random label", stateLabel, mState);
      mState = ri ? S_B : modelNext(mState, rx);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, errs);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", applied, errs);
      $finish;
    end
  end
endmodule